// File: doc/BRIEF.md
# Stream-to-Memory FIFO Writer

This block takes words from a valid/ready stream and stores each one in a circular region of external memory. It writes through a simple native write port. That port has two channels. The command channel carries valid, ready, a write-enable and an address. The data channel carries valid, ready and the word. The block keeps the write side of the memory FIFO's pointer logic: a wrapping write pointer and a fill level. Each accepted word raises the level. Each release pulse from the read side lowers it.

Input backpressure does not come from a local storage full flag. It comes from a programmable write threshold on the fill level. Once the level reaches the threshold, the sink is held off until the read side frees space. Each committed word also produces a one-cycle write strobe for the rest of the FIFO logic.

Top module: `stream_mem_writer`

## Requirements
- R1: After reset the fill level is 0, the command address is BASE, the write strobe is low, and `sink_ready` is high as soon as both memory channels are ready.
- R2: The n-th accepted word (counting from 0) is written to address BASE + (n mod DEPTH), so the region is reused circularly. The command address changes only when a word is accepted.
- R3: Words reach the data channel unchanged and in acceptance order. `cmd_we` is 1 whenever `cmd_valid` is high.
- R4: `sink_ready` equals (fill level < WR_THRESH) AND `cmd_ready` AND `wdata_ready`. A word is accepted exactly when both memory channels complete their handshakes in that same cycle, and never on one channel alone.
- R5: `wr_strobe` is high for exactly one cycle, in the cycle after each accepted word, and at no other time.
- R6: The fill level rises by one for each accepted word and falls by one for each honoured `rd_release`. Both in the same cycle leave it unchanged.
- R7: While the fill level is at or above WR_THRESH, `sink_ready` is low and no word is accepted, for as long as that lasts. One release re-admits one word.
- R8: An `rd_release` while the fill level is 0 is ignored: the level stays 0.
- R9: At most one word is written per cycle. No word is dropped or duplicated under random gaps on the sink and random stalls on the memory channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sink_valid | input | 1 | Input word valid |
| sink_ready | output | 1 | Input word accepted when high with valid |
| sink_data | input | DW | Input word |
| cmd_valid | output | 1 | Write command valid |
| cmd_ready | input | 1 | Memory accepts command |
| cmd_we | output | 1 | Write-enable, always 1 |
| cmd_addr | output | AW | Target word address |
| wdata_valid | output | 1 | Write data valid |
| wdata_ready | input | 1 | Memory accepts data |
| wdata_data | output | DW | Word to write |
| rd_release | input | 1 | Read side frees one slot |
| wr_strobe | output | 1 | One-cycle pulse per committed word |
| fill_level | output | $clog2(DEPTH+1) | Words currently held in the region |

## Verification
Most results are combinational. The handshake decision, the command address and the data are due in the same cycle as the stimulus that causes them. The fill level, the next address and `wr_strobe` are due one clock edge after an accepted word or a release.

The bench drives its inputs just after the rising edge and samples every output at the falling edge. It keeps a level model and a one-cycle-delayed copy of the acceptance event. It compares `fill_level` and `wr_strobe` against these one edge later. Address and data are popped from the scoreboard queue in the same falling-edge sample where both channels complete.

// File: rtl/stream_mem_writer.sv
module stream_mem_writer #(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int BASE      = 8,
  parameter int DEPTH     = 32,
  parameter int WR_THRESH = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sink_valid,
  output logic          sink_ready,
  input  logic [DW-1:0] sink_data,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_we,
  output logic [AW-1:0] cmd_addr,
  output logic          wdata_valid,
  input  logic          wdata_ready,
  output logic [DW-1:0] wdata_data,
  input  logic          rd_release,
  output logic          wr_strobe,
  output logic [LW-1:0] fill_level
);

  logic [PW-1:0] ptr_q;
  logic [LW-1:0] level_q;
  logic          writable, accept, release_ok;

  assign writable   = level_q < LW'(WR_THRESH);
  assign sink_ready = writable & cmd_ready & wdata_ready;
  assign accept     = sink_valid & sink_ready;
  assign release_ok = rd_release & (level_q != '0);

  assign cmd_valid   = sink_valid & writable & wdata_ready;
  assign wdata_valid = sink_valid & writable & cmd_ready;
  assign cmd_we      = 1'b1;
  assign cmd_addr    = AW'(BASE) + AW'(ptr_q);
  assign wdata_data  = sink_data;
  assign fill_level  = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      level_q   <= '0;
      wr_strobe <= 1'b0;
    end else begin
      wr_strobe <= accept;
      if (accept)
        ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      if (accept && !release_ok)
        level_q <= level_q + 1'b1;
      else if (!accept && release_ok)
        level_q <= level_q - 1'b1;
    end
  end

endmodule

module stream_mem_writer_chk #(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int DEPTH     = 32,
  parameter int WR_THRESH = 32,
  parameter int LW        = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sink_valid,
  input logic          sink_ready,
  input logic [DW-1:0] sink_data,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_we,
  input logic [AW-1:0] cmd_addr,
  input logic          wdata_valid,
  input logic          wdata_ready,
  input logic [DW-1:0] wdata_data,
  input logic          rd_release,
  input logic          wr_strobe,
  input logic [LW-1:0] fill_level
);

  // R7
  ready_below_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sink_ready |-> (fill_level < LW'(WR_THRESH)));

  // R4
  joint_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && sink_ready) |-> (cmd_valid && cmd_ready && wdata_valid && wdata_ready));

  // R4
  no_lone_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (wdata_valid && wdata_ready && sink_ready));

  // R5
  strobe_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(sink_valid && sink_ready));

  // R6
  level_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LW'(DEPTH));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sink_valid && sink_ready) |=> $stable(cmd_addr));

  // R3
  we_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_we);

  // R3
  data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid |-> (wdata_data == sink_data));

  // R8
  empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && rd_release && !(sink_valid && sink_ready)) |=> (fill_level == '0));

endmodule

bind stream_mem_writer stream_mem_writer_chk #(
  .DW(DW), .AW(AW), .DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sink_valid(sink_valid), .sink_ready(sink_ready),
  .sink_data(sink_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_we(cmd_we), .cmd_addr(cmd_addr), .wdata_valid(wdata_valid),
  .wdata_ready(wdata_ready), .wdata_data(wdata_data), .rd_release(rd_release),
  .wr_strobe(wr_strobe), .fill_level(fill_level)
);

// File: tb/stream_mem_writer_tb.sv
module stream_mem_writer_tb;
  localparam int DW = 32, AW = 32, BASE = 16, DEPTH = 8, THR = 6;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sink_valid = 1'b0, cmd_ready = 1'b1, wdata_ready = 1'b1, rd_release = 1'b0;
  logic [DW-1:0] sink_data = '0;
  logic sink_ready, cmd_valid, cmd_we, wdata_valid, wr_strobe;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wdata_data;
  logic [LW-1:0] fill_level;

  stream_mem_writer #(.DW(DW), .AW(AW), .BASE(BASE), .DEPTH(DEPTH), .WR_THRESH(THR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sink_valid(sink_valid), .sink_ready(sink_ready),
    .sink_data(sink_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
    .wdata_data(wdata_data), .rd_release(rd_release), .wr_strobe(wr_strobe),
    .fill_level(fill_level));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, issued = 0, popped = 0;
  logic [63:0] exp_q[$];
  int lvl_m = 0;
  logic prev_fire = 1'b0;
  logic rand_mem = 1'b0, rand_rel = 1'b0, mon_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: pushes expected address/data, then offers the word
  task automatic send(input logic [DW-1:0] d, input int gap);
    sink_valid = 1'b0;
    repeat (gap) begin @(posedge clk); #1; end
    exp_q.push_back({AW'(BASE + (issued % DEPTH)), d});
    issued++;
    sink_valid = 1'b1;
    sink_data  = d;
    do @(negedge clk); while (!sink_ready);
    @(posedge clk); #1;
    sink_valid = 1'b0;
  endtask

  // random stimulus on memory readiness and releases
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rand_mem) begin cmd_ready = lfsr[0] | lfsr[3]; wdata_ready = lfsr[1] | lfsr[5]; end
    if (rand_rel) rd_release = lfsr[2] & lfsr[7];
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      logic fire, mfire;
      logic [63:0] e;
      fire  = sink_valid & sink_ready;
      mfire = cmd_valid & cmd_ready & wdata_valid & wdata_ready;
      check(fire == mfire, "R4 joint handshake", mfire, fire);
      check(sink_ready == ((lvl_m < THR) && cmd_ready && wdata_ready), "R4/R7 sink_ready", sink_ready,
            (lvl_m < THR) && cmd_ready && wdata_ready);
      check(wr_strobe == prev_fire, "R5 strobe", wr_strobe, prev_fire);
      check(fill_level == LW'(lvl_m), "R6 level", fill_level, lvl_m);
      if (cmd_valid) check(cmd_we == 1'b1, "R3 write enable", cmd_we, 1);
      if (mfire) begin
        if (exp_q.size() == 0) check(1'b0, "R9 unexpected word", wdata_data, 0);
        else begin
          e = exp_q.pop_front();
          popped++;
          check(cmd_addr == e[63:32], "R2 address", cmd_addr, e[63:32]);
          check(wdata_data == e[31:0], "R3 data order", wdata_data, e[31:0]);
        end
      end
      prev_fire = fire;
      lvl_m = lvl_m + (fire ? 1 : 0) - ((rd_release && lvl_m != 0) ? 1 : 0);
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(fill_level == 0, "R1 level", fill_level, 0);
    check(cmd_addr == BASE, "R1 address", cmd_addr, BASE);
    check(wr_strobe == 0, "R1 strobe", wr_strobe, 0);
    check(sink_ready == 1, "R1 ready", sink_ready, 1);
    mon_on = 1'b1;

    // R8: release while empty
    @(posedge clk); #1 rd_release = 1'b1;
    @(posedge clk); #1 rd_release = 1'b0;
    @(negedge clk);
    check(fill_level == 0, "R8 empty release", fill_level, 0);

    // back-to-back then R9 random gaps and stalls
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1 rd_release = 1'b1;
      send(32'hA000_0000 + i, 0);
      rd_release = 1'b0;
    end
    rand_mem = 1'b1; rand_rel = 1'b1;
    for (int i = 0; i < 40; i++) send(32'h5000_0000 + i * 7, i % 3);

    // R7: drain to empty, fill to threshold, then stall
    rand_mem = 1'b0; rand_rel = 1'b0; cmd_ready = 1'b1; wdata_ready = 1'b1;
    rd_release = 1'b1;
    while (lvl_m != 0) @(posedge clk);
    #1 rd_release = 1'b0;
    for (int i = 0; i < THR; i++) send(32'hC000_0000 + i, 0);
    exp_q.push_back({AW'(BASE + (issued % DEPTH)), 32'hDEAD_0001});
    issued++;
    sink_valid = 1'b1; sink_data = 32'hDEAD_0001;
    repeat (20) begin
      @(negedge clk);
      check(sink_ready == 0 && fill_level == THR, "R7 stall", {sink_ready, fill_level}, THR);
    end
    @(posedge clk); #1 rd_release = 1'b1;
    @(posedge clk); #1 rd_release = 1'b0;
    do @(negedge clk); while (!sink_ready);
    @(posedge clk); #1 sink_valid = 1'b0;
    @(negedge clk);
    check(fill_level == THR, "R7 one admitted", fill_level, THR);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0 && popped == issued, "R9 all words written", popped, issued);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule